// File: doc/BRIEF.md
# Recorder Power and Acquisition Mode Sequencer

This block is the top-level mode controller of a battery-powered transient recorder. It decides which supply rails and the crystal oscillator are enabled, and it drives two status lamps. The unit sits asleep with only the logic supply on until an active-low arm command arrives. Arming powers the positive and negative analog rails and the oscillator, and the red lamp starts to flash.

While armed, the sequencer follows the recording segments that the trigger logic reports. A segment-complete pulse holds the red lamp steady. A segment-start pulse from the next trigger makes it flash again. Acquisition ends when the memory reports full or when an operator applies the forced-read input. At that point the negative rail and the oscillator are switched off, the red lamp goes dark and the green lamp signals that data is ready. An active-low disarm command then returns the unit to sleep.

All inputs are asynchronous and pass through two-flop synchronizers. Commands act on the edge at which they become active. A command that does not belong to the current mode has no effect.

Top module: `rec_mode_top`

## Requirements
- R1: After reset the unit is in sleep: `logic_rail_en`=1, `pos_rail_en`=0, `neg_rail_en`=0, `osc_en`=0, `led_red`=1 (steady), `led_green`=0.
- R2: A falling edge on `arm_n` in sleep enters the armed mode. The armed mode has `pos_rail_en`, `neg_rail_en`, `osc_en` and `logic_rail_en` all at 1, and `led_green`=0.
- R3: While armed, `led_red` is 1 for the first HALF cycles after entry, 0 for the next HALF, and keeps alternating this way. HALF = CLK_HZ/(2*BLINK_HZ).
- R4: A rising edge on `seg_done` while armed enters the hold mode. In hold, `led_red`=1 steady and all rails and the oscillator stay on.
- R5: A rising edge on `seg_start` in hold returns the unit to armed, and flashing restarts with the phase described in R3.
- R6: `mem_full`=1 while armed or in hold enters the ready mode. Ready has `pos_rail_en`=1, `logic_rail_en`=1, `neg_rail_en`=0, `osc_en`=0, `led_red`=0 and `led_green`=1.
- R7: `force_read`=1 while armed or in hold enters the ready mode, exactly as R6 does.
- R8: When an end condition (`mem_full` or `force_read`) and a `seg_done` edge arrive in the same cycle, the end condition wins and the unit goes to ready.
- R9: A falling edge on `disarm_n` in ready returns the unit to sleep, with the outputs given in R1.
- R10: The following inputs are ignored: `arm_n` outside sleep, `disarm_n` outside ready, `seg_done`/`seg_start` in sleep or ready, and `mem_full`/`force_read` in sleep or ready.
- R11: An input change takes effect on the outputs at the third rising clock edge after it is applied. Two of those edges are synchronizer stages and one is the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock from the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_n | input | 1 | Active-low arm command (asynchronous) |
| disarm_n | input | 1 | Active-low power-down command (asynchronous) |
| seg_done | input | 1 | Pulse: a recording segment has finished |
| seg_start | input | 1 | Pulse: a new trigger has started a segment |
| mem_full | input | 1 | Level: record memory is full |
| force_read | input | 1 | Level: manual forced end of sampling |
| logic_rail_en | output | 1 | Logic supply enable, always on |
| pos_rail_en | output | 1 | Positive analog rail enable |
| neg_rail_en | output | 1 | Negative analog rail enable |
| osc_en | output | 1 | Crystal oscillator enable |
| led_red | output | 1 | Red lamp drive: steady or flashing |
| led_green | output | 1 | Green lamp drive: data ready |

## Verification
Every mode change is due at the third rising edge after an input is applied. The bench drives inputs on a falling edge and samples at the falling edge after that third rising edge. For one input, the bench also samples one edge earlier to confirm that nothing has moved yet. The flash phase is counted from the edge at which the armed mode is entered. The bench reads the red lamp at the last cycle of each half-period and at the first cycle of the next half-period, so a counter that is off by one cycle is seen. The table checks skip the red lamp while the unit is armed, because its phase there depends on how long the unit has been armed.

// File: rtl/rec_mode_pkg.sv
package rec_mode_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP = 2'd0,
        MODE_ARMED = 2'd1,
        MODE_HOLD  = 2'd2,
        MODE_READY = 2'd3
    } mode_e;

    // synchronized input vector positions
    localparam int IN_ARM    = 0;
    localparam int IN_DISARM = 1;
    localparam int IN_DONE   = 2;
    localparam int IN_START  = 3;
    localparam int IN_FULL   = 4;
    localparam int IN_FORCE  = 5;
    localparam int IN_W      = 6;

    // idle levels: the two commands are active low
    localparam logic [IN_W-1:0] IN_IDLE = 6'b000011;

    typedef struct packed {
        mode_e mode;
        logic  arm_prev;
        logic  disarm_prev;
        logic  done_prev;
        logic  start_prev;
    } fsm_reg_t;

endpackage

// File: rtl/rec_in_sync.sv
module rec_in_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_d, s2_d;
        always_comb begin
            s1_d = async_i[i];
            s2_d = stage1_q[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q[i] <= RST_VAL[i];
                stage2_q[i] <= RST_VAL[i];
            end else begin
                stage1_q[i] <= s1_d;
                stage2_q[i] <= s2_d;
            end
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/rec_blink_div.sv
module rec_blink_div #(
    parameter int CLK_HZ   = 4_000_000,
    parameter int BLINK_HZ = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic phase_o
);
    localparam int HALF = CLK_HZ / (2 * BLINK_HZ);
    localparam int CW   = (HALF > 2) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phase;
    } blink_t;

    blink_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            r_d.cnt   = '0;
            r_d.phase = 1'b1;
        end else if (r_q.cnt == LAST) begin
            r_d.cnt   = '0;
            r_d.phase = ~r_q.phase;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cnt: '0, phase: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign phase_o = r_q.phase;

    // R3: the phase holds between wrap points of the counter
    assert_blink_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && r_q.cnt != '0) |-> $stable(r_q.phase));

    // R3: every new run starts lit
    assert_blink_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> r_q.phase);
endmodule

// File: rtl/rec_mode_fsm.sv
module rec_mode_fsm
    import rec_mode_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] in_s,
    output mode_e           mode_o
);
    fsm_reg_t r_d, r_q;

    logic arm_fall, disarm_fall, done_rise, start_rise, end_req;

    always_comb begin
        arm_fall    = !in_s[IN_ARM]    &&  r_q.arm_prev;
        disarm_fall = !in_s[IN_DISARM] &&  r_q.disarm_prev;
        done_rise   =  in_s[IN_DONE]   && !r_q.done_prev;
        start_rise  =  in_s[IN_START]  && !r_q.start_prev;
        end_req     =  in_s[IN_FULL]   ||  in_s[IN_FORCE];

        r_d             = r_q;
        r_d.arm_prev    = in_s[IN_ARM];
        r_d.disarm_prev = in_s[IN_DISARM];
        r_d.done_prev   = in_s[IN_DONE];
        r_d.start_prev  = in_s[IN_START];

        unique case (r_q.mode)
            MODE_SLEEP: if (arm_fall)    r_d.mode = MODE_ARMED;
            MODE_ARMED: begin
                if (end_req)             r_d.mode = MODE_READY;
                else if (done_rise)      r_d.mode = MODE_HOLD;
            end
            MODE_HOLD: begin
                if (end_req)             r_d.mode = MODE_READY;
                else if (start_rise)     r_d.mode = MODE_ARMED;
            end
            MODE_READY: if (disarm_fall) r_d.mode = MODE_SLEEP;
            default:                     r_d.mode = MODE_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{mode: MODE_SLEEP, arm_prev: 1'b1, disarm_prev: 1'b1,
                     done_prev: 1'b0, start_prev: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_o = r_q.mode;

    // R2: sleep can only be left towards armed
    assert_sleep_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.mode) == MODE_SLEEP && r_q.mode != MODE_SLEEP) |-> r_q.mode == MODE_ARMED);

    // R9: ready can only be left towards sleep
    assert_ready_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.mode) == MODE_READY && r_q.mode != MODE_READY) |-> r_q.mode == MODE_SLEEP);

    // R8: an end request during acquisition always lands in ready
    assert_end_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.mode == MODE_ARMED || r_q.mode == MODE_HOLD) && end_req) |=> r_q.mode == MODE_READY);

    // R4: a segment end without an end request lands in hold
    assert_seg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == MODE_ARMED && done_rise && !end_req) |=> r_q.mode == MODE_HOLD);

    // R10: entering ready requires an end request
    assert_ready_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == MODE_READY && $past(r_q.mode) != MODE_READY)
            |-> ($past(in_s[IN_FULL]) || $past(in_s[IN_FORCE])));
endmodule

// File: rtl/rec_mode_top.sv
module rec_mode_top
    import rec_mode_pkg::*;
#(
    parameter int CLK_HZ   = 4_000_000,
    parameter int BLINK_HZ = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_n,
    input  logic disarm_n,
    input  logic seg_done,
    input  logic seg_start,
    input  logic mem_full,
    input  logic force_read,
    output logic logic_rail_en,
    output logic pos_rail_en,
    output logic neg_rail_en,
    output logic osc_en,
    output logic led_red,
    output logic led_green
);
    logic [IN_W-1:0] raw_in, sync_in;
    mode_e           mode;
    logic            blink_phase;

    always_comb begin
        raw_in            = '0;
        raw_in[IN_ARM]    = arm_n;
        raw_in[IN_DISARM] = disarm_n;
        raw_in[IN_DONE]   = seg_done;
        raw_in[IN_START]  = seg_start;
        raw_in[IN_FULL]   = mem_full;
        raw_in[IN_FORCE]  = force_read;
    end

    rec_in_sync #(.W(IN_W), .RST_VAL(IN_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    rec_mode_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_s   (sync_in),
        .mode_o (mode)
    );

    rec_blink_div #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (mode == MODE_ARMED),
        .phase_o (blink_phase)
    );

    always_comb begin
        logic_rail_en = 1'b1;
        pos_rail_en   = (mode != MODE_SLEEP);
        neg_rail_en   = (mode == MODE_ARMED) || (mode == MODE_HOLD);
        osc_en        = (mode == MODE_ARMED) || (mode == MODE_HOLD);
        led_green     = (mode == MODE_READY);
        unique case (mode)
            MODE_SLEEP: led_red = 1'b1;
            MODE_ARMED: led_red = blink_phase;
            MODE_HOLD:  led_red = 1'b1;
            default:    led_red = 1'b0;
        endcase
    end

    // R6: once data is ready the negative rail and oscillator are off
    assert_ready_rails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        led_green |-> (!neg_rail_en && !osc_en && pos_rail_en && !led_red));

    // R2: the oscillator never runs without both analog rails
    assert_osc_rails_R2: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en |-> (pos_rail_en && neg_rail_en && !led_green));

    // R1: without the positive rail the red lamp is lit steadily
    assert_sleep_lamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_rail_en |-> (led_red && !led_green && !osc_en));
endmodule

// File: tb/rec_mode_top_test.sv
module rec_mode_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 32;
    localparam int BLINK_HZ   = 2;
    localparam int HALF       = CLK_HZ / (2 * BLINK_HZ);
    localparam int WATCHDOG   = 20000;

    // stim bits: {force, full, start, done, disarm, arm}; 1 = assert
    // red: 0/1 expected, 2 = not checked (flashing)
    typedef struct packed {
        logic [5:0] stim;
        logic       pos;
        logic       neg;
        logic       osc;
        logic [1:0] red;
        logic       green;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TABLE [NV] = '{
        '{6'b000000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'd1 },  // R1 idle sleep
        '{6'b000010, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'd10},  // R10 disarm in sleep
        '{6'b000100, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'd10},  // R10 done in sleep
        '{6'b010000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'd10},  // R10 full in sleep
        '{6'b000001, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd2 },  // R2 arm
        '{6'b000001, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd10},  // R10 arm again
        '{6'b000010, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd10},  // R10 disarm while armed
        '{6'b000100, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 4'd4 },  // R4 hold
        '{6'b001000, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd5 },  // R5 resume
        '{6'b000100, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 4'd4 },  // R4 hold again
        '{6'b000010, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 4'd10},  // R10 disarm in hold
        '{6'b100000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd7 },  // R7 forced read
        '{6'b000001, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd10},  // R10 arm in ready
        '{6'b001000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd10},  // R10 start in ready
        '{6'b000010, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'd9 },  // R9 power down
        '{6'b000001, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd2 },  // R2 arm
        '{6'b010000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd6 },  // R6 memory full
        '{6'b000010, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'd9 },  // R9 power down
        '{6'b000001, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 4'd2 },  // R2 arm
        '{6'b010100, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd8 },  // R8 full beats done
        '{6'b000010, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'd9 },  // R9 power down
        '{6'b001000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 4'd10}   // R10 start in sleep
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm_n = 1'b1, disarm_n = 1'b1;
    logic seg_done = 1'b0, seg_start = 1'b0, mem_full = 1'b0, force_read = 1'b0;
    logic logic_rail_en, pos_rail_en, neg_rail_en, osc_en, led_red, led_green;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rec_mode_top #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_n         (arm_n),
        .disarm_n      (disarm_n),
        .seg_done      (seg_done),
        .seg_start     (seg_start),
        .mem_full      (mem_full),
        .force_read    (force_read),
        .logic_rail_en (logic_rail_en),
        .pos_rail_en   (pos_rail_en),
        .neg_rail_en   (neg_rail_en),
        .osc_en        (osc_en),
        .led_red       (led_red),
        .led_green     (led_green)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // drive for one clock at a falling edge, then return to idle
    task automatic pulse(input logic [5:0] s);
        arm_n      = ~s[0];
        disarm_n   = ~s[1];
        seg_done   =  s[2];
        seg_start  =  s[3];
        mem_full   =  s[4];
        force_read =  s[5];
        @(posedge clk);
        @(negedge clk);
        arm_n = 1'b1; disarm_n = 1'b1;
        seg_done = 1'b0; seg_start = 1'b0; mem_full = 1'b0; force_read = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        edges(2);
        rst_n = 1'b1;
        edges(1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset state
        check("R1", "logic_rail_en", logic_rail_en, 1'b1);
        check("R1", "pos_rail_en",   pos_rail_en,   1'b0);
        check("R1", "neg_rail_en",   neg_rail_en,   1'b0);
        check("R1", "osc_en",        osc_en,        1'b0);
        check("R1", "led_red",       led_red,       1'b1);
        check("R1", "led_green",     led_green,     1'b0);

        // table walk: result due at the third rising edge after the stimulus
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TABLE[i].req, i);
            pulse(TABLE[i].stim);
            edges(2);
            check(tag, "logic_rail_en", logic_rail_en, 1'b1);
            check(tag, "pos_rail_en",   pos_rail_en,   TABLE[i].pos);
            check(tag, "neg_rail_en",   neg_rail_en,   TABLE[i].neg);
            check(tag, "osc_en",        osc_en,        TABLE[i].osc);
            check(tag, "led_green",     led_green,     TABLE[i].green);
            if (TABLE[i].red != 2'd2)
                check(tag, "led_red", led_red, TABLE[i].red[0]);
            edges(2);
        end

        // R3: flash phase counted from entry at the third edge
        do_reset();
        pulse(6'b000001);
        edges(3 + HALF - 1 - 1);
        check("R3", "red last lit cycle", led_red, 1'b1);
        edges(1);
        check("R3", "red first dark cycle", led_red, 1'b0);
        edges(HALF - 1);
        check("R3", "red last dark cycle", led_red, 1'b0);
        edges(1);
        check("R3", "red relit", led_red, 1'b1);

        // R5: resume after hold restarts the phase
        pulse(6'b000100);
        edges(2);
        check("R5", "red steady in hold", led_red, 1'b1);
        edges(2 * HALF);
        check("R5", "red still steady in hold", led_red, 1'b1);
        pulse(6'b001000);
        edges(2 + HALF - 1);
        check("R5", "red lit through first half", led_red, 1'b1);
        edges(1);
        check("R5", "red dark after first half", led_red, 1'b0);

        // R11: forced read not visible after two edges, visible after three
        force_read = 1'b1;
        edges(2);
        check("R11", "green after two edges", led_green, 1'b0);
        check("R11", "osc after two edges", osc_en, 1'b1);
        edges(1);
        check("R11", "green after three edges", led_green, 1'b1);
        check("R11", "osc after three edges", osc_en, 1'b0);
        force_read = 1'b0;
        edges(2);

        // R10: held arm level in ready does nothing, then a disarm edge sleeps (R9)
        arm_n = 1'b0;
        edges(5);
        check("R10", "green with arm held in ready", led_green, 1'b1);
        pulse(6'b000010);
        edges(2);
        check("R9", "pos rail after disarm", pos_rail_en, 1'b0);
        edges(3);
        check("R10", "held arm level does not re-arm", osc_en, 1'b0);
        arm_n = 1'b1;
        edges(2);

        // R1: reset from ready returns to sleep
        pulse(6'b000001);
        edges(2);
        pulse(6'b010000);
        edges(2);
        check("R6", "green before reset", led_green, 1'b1);
        do_reset();
        check("R1", "green after reset", led_green, 1'b0);
        check("R1", "pos rail after reset", pos_rail_en, 1'b0);
        check("R1", "red after reset", led_red, 1'b1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule